// File: doc/BRIEF.md
# Dual-Port Shared Memory with Collision Arbitration and Mailbox Flags

This block is a byte-wide shared memory that two agents, called left and right, reach through two independent access ports. Each port has its own select, write strobe, output enable, address, write data, read data, a contention flag and a mailbox interrupt flag. The depth is set by an address-width parameter: 10 bits gives 1024 words and 11 bits gives 2048 words. Everything is clocked by one clock. Each port makes at most one access per cycle.

When both ports select the same word in the same cycle and at least one of them writes, the left port wins. The right port sees its contention flag in that same cycle, and any write it attempts is dropped. Two reads of one word never collide.

The top two words act as mailboxes. The word at depth-2 belongs to the left port and the word at depth-1 belongs to the right port. A write by one port into the other port's mailbox raises the owner's interrupt flag. The owner clears the flag by reading its mailbox. No port has back-pressure: there is no valid/ready pair, and a selected port is always served in its cycle, with the contention flag as the only way a right-port write is refused.

Top module: `dual_port_ram`

## Requirements
- R1: While `rst` is high and in the first cycle after it, both read-data outputs, both contention flags and both mailbox flags are zero.
- R2: A port access happens when its select is 1; the write strobe (1 = write, 0 = read) picks the kind. Write data is stored at the rising edge. Read data shows the word's contents on the port's read-data output after that same rising edge, one cycle after the access is presented. The two ports work independently on different words in the same cycle.
- R3: A port's read-data output is non-zero only in the cycle after that port presented select=1, write=0 and output enable=1; otherwise it is all zeros. A write presented with select=0 does not change the memory.
- R4: Both ports reading the same word in the same cycle both receive its data, and neither contention flag rises.
- R5: When both ports are selected at the same address and at least one writes, the right contention flag is 1 in that same cycle. The left contention flag is always 0.
- R6: When both ports write the same word in the same cycle, the left data is stored and the right data is discarded.
- R7: In a read/write collision, the read returns the word's contents from before that cycle. A right-port write that collides with a left-port read is discarded.
- R8: An accepted left write to address depth-1 sets the right mailbox flag, and an accepted right write to address depth-2 sets the left mailbox flag. Each flag changes after the rising edge that takes the write. A right write dropped by arbitration sets nothing.
- R9: A selected read by a port of its own mailbox word (left: depth-2, right: depth-1) clears that port's flag after the edge, whatever its output enable is. If a set and a clear of the same flag happen in the same cycle, the set wins.
- R10: A write by a port into its own mailbox, and any other access, leaves both mailbox flags unchanged. The mailbox words hold data like any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left port select (access enable) |
| l_write | input | 1 | Left port 1 = write, 0 = read |
| l_out_en | input | 1 | Left port read-data output enable |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port read data, zero when not driven |
| l_clash | output | 1 | Left contention flag (left has priority, stays 0) |
| l_mbox_irq | output | 1 | Left mailbox interrupt flag |
| r_sel | input | 1 | Right port select (access enable) |
| r_write | input | 1 | Right port 1 = write, 0 = read |
| r_out_en | input | 1 | Right port read-data output enable |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port read data, zero when not driven |
| r_clash | output | 1 | Right contention flag, same cycle as the collision |
| r_mbox_irq | output | 1 | Right mailbox interrupt flag |

## Verification
The bench aims at both kinds of same-address collision. If the priority were lost, a write-write collision would leave the right data in the word, or a dropped right write would slip through when it collides with a left read. Collision reads must return the old contents; a design that forwards new data would return the incoming write instead. The mailbox tests cover ordering: set before clear, a set and a clear in the same cycle where the set must win, a set suppressed by arbitration, and writes into a port's own mailbox. A design that confuses the two mailbox words, or lets the clear win, would show the wrong flag level one cycle after the access. The output gating test reads with the output enable low. This catches a design that drives stale read data, or one that lets a deselected write reach the array.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Control pins of one access port, already sampled at the block edge.
  typedef struct packed {
    logic sel;     // port performs an access this cycle
    logic write;   // 1 = write, 0 = read
    logic out_en;  // read data may be driven next cycle
  } port_ctl_t;

  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int NUM_SIDES = 2;

  function automatic logic is_read(input port_ctl_t c);
    return c.sel && !c.write;
  endfunction

  function automatic logic is_write(input port_ctl_t c);
    return c.sel && c.write;
  endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         l_ctl,
  input  port_ctl_t         r_ctl,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_wr_ok,
  output logic              r_wr_ok,
  output logic              l_clash,
  output logic              r_clash
);

  logic same_word;
  logic conflict;

  // Same word, both selected, and at least one writer: left has priority.
  assign same_word = l_ctl.sel && r_ctl.sel && (l_addr == r_addr);
  assign conflict  = same_word && (l_ctl.write || r_ctl.write);

  assign l_clash = 1'b0;
  assign r_clash = conflict;
  assign l_wr_ok = is_write(l_ctl);
  assign r_wr_ok = is_write(r_ctl) && !conflict;

  AST_DUAL_READ_FREE: assert property (@(posedge clk) disable iff (rst)
    (is_read(l_ctl) && is_read(r_ctl)) |-> !r_clash); // R4

  AST_CLASH_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    r_clash |-> (l_addr == r_addr) && l_ctl.sel && r_ctl.sel); // R5

endmodule

// File: rtl/dpr_array.sv
module dpr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_l,
  input  logic              we_r,
  input  logic              re_l,
  input  logic              re_r,
  input  logic [ADDR_W-1:0] a_l,
  input  logic [ADDR_W-1:0] a_r,
  input  logic [DATA_W-1:0] d_l,
  input  logic [DATA_W-1:0] d_r,
  output logic [DATA_W-1:0] q_l,
  output logic [DATA_W-1:0] q_r
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Reads see contents from before this edge (read-before-write).
  always_ff @(posedge clk) begin
    if (we_l) store[a_l] <= d_l;
    if (we_r) store[a_r] <= d_r;
    if (re_l) q_l <= store[a_l];
    if (re_r) q_r <= store[a_r];
  end

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(we_l && we_r && (a_l == a_r))); // R6

endmodule

// File: rtl/dpr_mailbox.sv
module dpr_mailbox #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_wr_ok,
  input  logic              r_wr_ok,
  input  logic              l_rd,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq,
  output logic              r_irq
);

  localparam logic [ADDR_W-1:0] BOX_R = '1;
  localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic l_set, l_clr, r_set, r_clr;

  // The other side fills a box; the owner empties it by reading.
  assign l_set = r_wr_ok && (r_addr == BOX_L);
  assign r_set = l_wr_ok && (l_addr == BOX_R);
  assign l_clr = l_rd && (l_addr == BOX_L);
  assign r_clr = r_rd && (r_addr == BOX_R);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_irq <= 1'b0;
      r_irq <= 1'b0;
    end else begin
      if (l_set)      l_irq <= 1'b1;
      else if (l_clr) l_irq <= 1'b0;
      if (r_set)      r_irq <= 1'b1;
      else if (r_clr) r_irq <= 1'b0;
    end
  end

  AST_RIGHT_BOX_SETS: assert property (@(posedge clk) disable iff (rst)
    (l_wr_ok && l_addr == BOX_R) |=> r_irq); // R8

  AST_LEFT_BOX_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (l_rd && l_addr == BOX_L && !(r_wr_ok && r_addr == BOX_L)) |=> !l_irq); // R9

  AST_RIGHT_IRQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(l_wr_ok && l_addr == BOX_R) && !(r_rd && r_addr == BOX_R)) |=> $stable(r_irq)); // R10

endmodule

// File: rtl/dpr_rd_gate.sv
module dpr_rd_gate
  import dpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  port_ctl_t         ctl,
  input  logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rdata
);

  logic drive_q;

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= is_read(ctl) && ctl.out_en;
  end

  assign rdata = drive_q ? q : '0;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(is_read(ctl) && ctl.out_en) |-> (rdata == '0)); // R3

endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sel,
  input  logic              l_write,
  input  logic              l_out_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_clash,
  output logic              l_mbox_irq,
  input  logic              r_sel,
  input  logic              r_write,
  input  logic              r_out_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_clash,
  output logic              r_mbox_irq
);

  port_ctl_t         ctl  [NUM_SIDES];
  logic [DATA_W-1:0] q    [NUM_SIDES];
  logic [DATA_W-1:0] rd   [NUM_SIDES];
  logic              wr_ok_l, wr_ok_r;

  assign ctl[SIDE_L] = '{sel: l_sel, write: l_write, out_en: l_out_en};
  assign ctl[SIDE_R] = '{sel: r_sel, write: r_write, out_en: r_out_en};

  dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .l_ctl   (ctl[SIDE_L]),
    .r_ctl   (ctl[SIDE_R]),
    .l_addr  (l_addr),
    .r_addr  (r_addr),
    .l_wr_ok (wr_ok_l),
    .r_wr_ok (wr_ok_r),
    .l_clash (l_clash),
    .r_clash (r_clash)
  );

  dpr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .rst  (rst),
    .we_l (wr_ok_l),
    .we_r (wr_ok_r),
    .re_l (is_read(ctl[SIDE_L])),
    .re_r (is_read(ctl[SIDE_R])),
    .a_l  (l_addr),
    .a_r  (r_addr),
    .d_l  (l_wdata),
    .d_r  (r_wdata),
    .q_l  (q[SIDE_L]),
    .q_r  (q[SIDE_R])
  );

  dpr_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
    .clk     (clk),
    .rst     (rst),
    .l_wr_ok (wr_ok_l),
    .r_wr_ok (wr_ok_r),
    .l_rd    (is_read(ctl[SIDE_L])),
    .r_rd    (is_read(ctl[SIDE_R])),
    .l_addr  (l_addr),
    .r_addr  (r_addr),
    .l_irq   (l_mbox_irq),
    .r_irq   (r_mbox_irq)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dpr_rd_gate #(.DATA_W(DATA_W)) u_gate (
      .clk   (clk),
      .rst   (rst),
      .ctl   (ctl[s]),
      .q     (q[s]),
      .rdata (rd[s])
    );
  end

  assign l_rdata = rd[SIDE_L];
  assign r_rdata = rd[SIDE_R];

  AST_LEFT_NEVER_WAITS: assert property (@(posedge clk) disable iff (rst)
    (l_sel && r_sel && l_addr == r_addr && r_write) |-> r_clash && !l_clash); // R5

endmodule

// File: tb/dual_port_ram_bench.sv
module dual_port_ram_bench;

  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;
  localparam int BOX_L = DEPTH - 2;
  localparam int BOX_R = DEPTH - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          l_sel = 0, l_write = 0, l_out_en = 0;
  logic [AW-1:0] l_addr = '0;
  logic [7:0]    l_wdata = '0;
  logic [7:0]    l_rdata;
  logic          l_clash, l_mbox_irq;
  logic          r_sel = 0, r_write = 0, r_out_en = 0;
  logic [AW-1:0] r_addr = '0;
  logic [7:0]    r_wdata = '0;
  logic [7:0]    r_rdata;
  logic          r_clash, r_mbox_irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_port_ram #(.ADDR_W(AW), .DATA_W(8)) u_dual_port_ram (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_write(l_write), .l_out_en(l_out_en), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_clash(l_clash), .l_mbox_irq(l_mbox_irq),
    .r_sel(r_sel), .r_write(r_write), .r_out_en(r_out_en), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_clash(r_clash), .r_mbox_irq(r_mbox_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drv_l(input bit s, input bit w, input bit oe, input int a, input int d);
    l_sel = s; l_write = w; l_out_en = oe; l_addr = AW'(a); l_wdata = 8'(d);
  endtask

  task automatic drv_r(input bit s, input bit w, input bit oe, input int a, input int d);
    r_sel = s; r_write = w; r_out_en = oe; r_addr = AW'(a); r_wdata = 8'(d);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, 0, 0);
    drv_r(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
    chk("R1 l_irq", l_mbox_irq, 0);
    chk("R1 r_irq", r_mbox_irq, 0);
    chk("R1 r_clash", r_clash, 0);
  endtask

  task automatic t_basic();
    drv_l(1, 1, 0, 'h010, 'h5A);
    drv_r(1, 1, 0, 'h020, 'hC3);
    #1 chk("R2 no clash distinct words", r_clash, 0);
    step();
    drv_l(1, 0, 1, 'h020, 0);
    drv_r(1, 0, 1, 'h010, 0);
    step();
    chk("R2 left reads right write", l_rdata, 'hC3);
    chk("R2 right reads left write", r_rdata, 'h5A);
    idle();
    step();
  endtask

  task automatic t_gate();
    drv_l(0, 1, 0, 'h010, 'hFF);
    step();
    drv_l(1, 0, 0, 'h010, 0);
    step();
    chk("R3 out_en low gives zero", l_rdata, 0);
    drv_l(1, 0, 1, 'h010, 0);
    step();
    chk("R3 deselected write ignored", l_rdata, 'h5A);
    idle();
    step();
    chk("R3 zero after idle", l_rdata, 0);
  endtask

  task automatic t_dual_read();
    drv_l(1, 0, 1, 'h010, 0);
    drv_r(1, 0, 1, 'h010, 0);
    #1 chk("R4 no clash on two reads", r_clash, 0);
    step();
    chk("R4 left data", l_rdata, 'h5A);
    chk("R4 right data", r_rdata, 'h5A);
    idle();
    step();
  endtask

  task automatic t_wr_wr();
    drv_l(1, 1, 0, 'h030, 'h11);
    drv_r(1, 1, 0, 'h030, 'h22);
    #1 chk("R5 right clash on double write", r_clash, 1);
    chk("R5 left never clashes", l_clash, 0);
    step();
    drv_l(1, 0, 1, 'h030, 0);
    drv_r(0, 0, 0, 0, 0);
    step();
    chk("R6 left data kept", l_rdata, 'h11);
    idle();
    step();
  endtask

  task automatic t_rd_wr();
    drv_l(1, 0, 1, 'h030, 0);
    drv_r(1, 1, 0, 'h030, 'h33);
    #1 chk("R5 clash on right write vs left read", r_clash, 1);
    step();
    chk("R7 left read sees old word", l_rdata, 'h11);
    drv_r(1, 0, 1, 'h030, 0);
    drv_l(0, 0, 0, 0, 0);
    step();
    chk("R7 right write dropped", r_rdata, 'h11);
    drv_l(1, 1, 0, 'h030, 'h44);
    drv_r(1, 0, 1, 'h030, 0);
    #1 chk("R5 clash on left write vs right read", r_clash, 1);
    step();
    chk("R7 right read sees old word", r_rdata, 'h11);
    drv_l(0, 0, 0, 0, 0);
    step();
    chk("R7 left write landed", r_rdata, 'h44);
    idle();
    step();
  endtask

  task automatic t_mailbox();
    drv_l(1, 1, 0, BOX_R, 'hA1);
    step();
    chk("R8 right irq set", r_mbox_irq, 1);
    chk("R8 left irq untouched", l_mbox_irq, 0);
    drv_l(0, 0, 0, 0, 0);
    drv_r(1, 0, 1, BOX_R, 0);
    step();
    chk("R9 right box data", r_rdata, 'hA1);
    chk("R9 right irq cleared", r_mbox_irq, 0);
    drv_r(1, 1, 0, BOX_L, 'hB2);
    step();
    chk("R8 left irq set", l_mbox_irq, 1);
    drv_r(0, 0, 0, 0, 0);
    drv_l(1, 1, 0, BOX_L, 'h77);
    step();
    chk("R10 own-box write keeps left irq", l_mbox_irq, 1);
    chk("R10 own-box write keeps right irq", r_mbox_irq, 0);
    drv_l(1, 0, 0, BOX_L, 0);
    step();
    chk("R9 left irq cleared with out_en low", l_mbox_irq, 0);
    drv_l(1, 0, 1, BOX_L, 0);
    step();
    chk("R10 left box holds data", l_rdata, 'h77);
    drv_l(1, 1, 0, BOX_R, 'h55);
    drv_r(1, 0, 1, BOX_R, 0);
    step();
    chk("R9 set beats clear", r_mbox_irq, 1);
    chk("R7 right box read is old", r_rdata, 'hA1);
    drv_l(0, 0, 0, 0, 0);
    step();
    chk("R9 right irq cleared again", r_mbox_irq, 0);
    chk("R9 right box new data", r_rdata, 'h55);
    drv_l(1, 0, 1, BOX_L, 0);
    drv_r(1, 1, 0, BOX_L, 'hEE);
    step();
    chk("R8 dropped write sets nothing", l_mbox_irq, 0);
    chk("R7 left box unchanged", l_rdata, 'h77);
    drv_l(0, 0, 0, 0, 0);
    drv_r(1, 1, 0, BOX_R, 'h99);
    step();
    chk("R10 right own-box write", r_mbox_irq, 0);
    chk("R10 left irq untouched", l_mbox_irq, 0);
    idle();
    step();
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_basic();
    t_gate();
    t_dual_read();
    t_wr_wr();
    t_rd_wr();
    t_mailbox();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule